// File: doc/BRIEF.md
# Bus-Hog Priority Request Arbiter

This arbiter picks which of seven memory clients may move its next 32-byte unit. Two clients read and five write. Each client holds a request line high while it has work pending. The arbiter issues a one-hot grant, the index of the granted client and a flag that marks a write. It keeps that grant until the memory side reports with a single-cycle `done` pulse that the transfer has finished. Only at that point, or while nothing is granted, does it make a new decision.

The decision has two layers. The first layer is the hog rule. When a transfer completes and its client is still requesting, that client is granted again, ahead of everyone else, so a client that is streaming keeps the bus. Two write clients never get this preference. After either of them completes, the decision falls straight through to the second layer. The second layer is a fixed order: both reads rank above all writes, read 0 ranks above read 1, and the writes rank from write 0 down to write 4.

Client indices are fixed:
- 0 is read 0.
- 1 is read 1.
- 2 to 6 are write 0 to write 4.

Top module: `hog_arb`

## Requirements
- R1: While reset is held and on leaving it, no grant is active: `gnt` = 0, `gnt_vld` = 0, `gnt_idx` = 0, `gnt_wr` = 0. The first decision after reset uses the fixed order only.
- R2: When `gnt_vld` is 1, `gnt` has exactly one bit set, at position `gnt_idx`, and `gnt_wr` is 1 exactly when `gnt_idx` ≥ 2. When `gnt_vld` is 0, `gnt` is all zero.
- R3: While a grant is active and `done` is low, the grant outputs do not change.
- R4: A decision is taken at a clock edge where either no grant is active or `done` is high. Its result appears on the outputs right after that same edge.
- R5: The fixed order grants the lowest requesting index. Reads (0, 1) therefore rank above every write, and write 0 (index 2) ranks above write 4 (index 6).
- R6: At a `done` edge, the client being served keeps the grant if its request is still high and it is not index 4 or 5. This holds even when a client of higher fixed rank is requesting.
- R7: Indices 4 and 5 (write 2 and write 3) are never preferred. After their `done`, the fixed order picks the next client.
- R8: If the served client's request is low at its `done` edge, it has no preference, and the fixed order picks among the clients still requesting.
- R9: If no request is high at a decision edge, `gnt_vld` falls to 0. A `done` pulse while nothing is granted has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 7 | Request per client. Bits 0–1 are reads, bits 2–6 are writes 0–4 |
| done | input | 1 | Single-cycle pulse: the granted transfer has finished |
| gnt | output | 7 | One-hot grant |
| gnt_vld | output | 1 | A grant is active |
| gnt_idx | output | 3 | Index of the granted client |
| gnt_wr | output | 1 | The granted client is a writer |

## Verification
The hog rule and the fixed order collide on one edge. A `done` pulse arrives while the served client is still requesting and a client of higher fixed rank is also requesting. Directed cases set up this collision with a read 0 request against a hogging read 1 client, and again with a write 4 client. Each case then checks that the served client kept the grant. The same collision with the two excluded writes and with a dropped request checks that the fixed winner takes the grant instead. Random requests and `done` pulses then drive many such edges, and a reference model written from the requirements judges each one.

// File: rtl/hog_arb.sv
module hog_arb #(
  parameter int NCLI = 7,
  parameter int NRD = 2,
  parameter logic [NCLI-1:0] HOG_EXCL = 7'b0110000,
  localparam int IW = $clog2(NCLI)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLI-1:0] req,
  input  logic            done,
  output logic [NCLI-1:0] gnt,
  output logic            gnt_vld,
  output logic [IW-1:0]   gnt_idx,
  output logic            gnt_wr
);

  logic          decide;
  logic          hog_hit;
  logic [IW-1:0] fix_idx;
  logic [IW-1:0] nxt_idx;

  assign decide  = !gnt_vld || done;
  assign hog_hit = gnt_vld && done && !HOG_EXCL[gnt_idx] && req[gnt_idx];

  always_comb begin
    fix_idx = '0;
    for (int i = NCLI - 1; i >= 0; i--)
      if (req[i]) fix_idx = IW'(i);
  end

  assign nxt_idx = hog_hit ? gnt_idx : fix_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt     <= '0;
      gnt_vld <= 1'b0;
      gnt_idx <= '0;
      gnt_wr  <= 1'b0;
    end else if (decide) begin
      if (|req) begin
        gnt     <= NCLI'(1) << nxt_idx;
        gnt_vld <= 1'b1;
        gnt_idx <= nxt_idx;
        gnt_wr  <= nxt_idx >= IW'(NRD);
      end else begin
        gnt     <= '0;
        gnt_vld <= 1'b0;
        gnt_idx <= '0;
        gnt_wr  <= 1'b0;
      end
    end
  end

endmodule

module hog_arb_chk #(
  parameter int NCLI = 7,
  parameter int NRD = 2,
  parameter logic [NCLI-1:0] HOG_EXCL = 7'b0110000,
  localparam int IW = $clog2(NCLI)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCLI-1:0] req,
  input logic            done,
  input logic [NCLI-1:0] gnt,
  input logic            gnt_vld,
  input logic [IW-1:0]   gnt_idx,
  input logic            gnt_wr
);

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> ($onehot(gnt) && gnt[gnt_idx]));

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld |-> (gnt == '0));

  a_r2_dir: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> (gnt_wr == (gnt_idx >= IW'(NRD))));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && !done) |=> (gnt_vld && $stable(gnt) && $stable(gnt_idx)));

  a_r6_hog: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && done && !HOG_EXCL[gnt_idx] && req[gnt_idx]) |=> (gnt_vld && $stable(gnt_idx)));

  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && done && HOG_EXCL[gnt_idx] && req[0]) |=> (gnt_vld && gnt_idx == '0));

  a_r9_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ((!gnt_vld || done) && req == '0) |=> !gnt_vld);

  a_r5_idle_top: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_vld && req[0]) |=> (gnt_vld && gnt_idx == '0));

endmodule

bind hog_arb hog_arb_chk #(.NCLI(NCLI), .NRD(NRD), .HOG_EXCL(HOG_EXCL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .done(done),
  .gnt(gnt), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx), .gnt_wr(gnt_wr)
);

// File: tb/sim_hog_arb.sv
module sim_hog_arb;
  localparam int CLK_PERIOD = 10;
  localparam int NCLI = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] req = '0;
  logic       done = 1'b0;
  logic [6:0] gnt;
  logic       gnt_vld;
  logic [2:0] gnt_idx;
  logic       gnt_wr;

  int n_chk = 0;
  int n_fail = 0;
  bit fin = 1'b0;

  hog_arb u0 (.clk(clk), .rst_n(rst_n), .req(req), .done(done),
              .gnt(gnt), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx), .gnt_wr(gnt_wr));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit excl(input logic [2:0] i);
    return (i == 3'd4) || (i == 3'd5);
  endfunction

  function automatic logic [2:0] lowest(input logic [6:0] r);
    for (int i = 0; i < NCLI; i++)
      if (r[i]) return 3'(i);
    return 3'd0;
  endfunction

  function automatic logic [2:0] pick(input logic [6:0] r, input bit vld, input bit dn,
                                      input logic [2:0] cur);
    if (vld && dn && !excl(cur) && r[cur]) return cur;
    return lowest(r);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic expect_grant(input string tag, input int idx);
    chk(gnt_vld == 1'b1, {tag, " vld"}, int'(gnt_vld), 1);
    chk(gnt_idx == 3'(idx), {tag, " idx"}, int'(gnt_idx), idx);
    chk(gnt == 7'(1 << idx), {tag, " onehot"}, int'(gnt), 1 << idx);
    chk(gnt_wr == (idx >= 2), {tag, " wr"}, int'(gnt_wr), int'(idx >= 2));
  endtask

  task automatic pulse_done();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  // reference model, built from the requirements
  logic       m_vld;
  logic [2:0] m_idx;
  bit         mdl_on = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld <= 1'b0;
      m_idx <= 3'd0;
    end else if (!m_vld || done) begin
      if (req != 7'd0) begin
        m_vld <= 1'b1;
        m_idx <= pick(req, m_vld, done, m_idx);
      end else begin
        m_vld <= 1'b0;
        m_idx <= 3'd0;
      end
    end
  end

  always @(negedge clk) begin
    if (mdl_on && rst_n) begin
      chk(gnt_vld == m_vld, "R4/R9 model vld", int'(gnt_vld), int'(m_vld));
      if (m_vld) begin
        chk(gnt_idx == m_idx, "R5/R6/R7/R8 model idx", int'(gnt_idx), int'(m_idx));
        chk(gnt == 7'(1 << m_idx), "R2 model onehot", int'(gnt), 1 << m_idx);
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(gnt == 7'd0 && !gnt_vld && gnt_idx == 3'd0 && !gnt_wr, "R1 reset",
        int'({gnt_vld, gnt}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!gnt_vld, "R1 idle after reset", int'(gnt_vld), 0);
    req = 7'b0001010;
    @(negedge clk);
    expect_grant("R1 first fixed", 1);
    req = 7'b0001011;
    repeat (2) @(negedge clk);
    expect_grant("R3 hold", 1);
    pulse_done();
    expect_grant("R6 read hog over read 0", 1);
    req = 7'b0001001;
    pulse_done();
    expect_grant("R8 dropped hog", 0);
    req = 7'b0010000;
    pulse_done();
    expect_grant("R2 write flag", 4);
    req = 7'b0010100;
    pulse_done();
    expect_grant("R7 write 2 excluded", 2);
    req = 7'b0100000;
    pulse_done();
    expect_grant("R5 single write 3", 5);
    req = 7'b0100100;
    pulse_done();
    expect_grant("R7 write 3 excluded", 2);
    req = 7'b1000000;
    pulse_done();
    expect_grant("R5 single write 4", 6);
    req = 7'b1000101;
    pulse_done();
    expect_grant("R6 write 4 hog over read 0", 6);
    req = 7'b0000000;
    pulse_done();
    chk(!gnt_vld && gnt == 7'd0, "R9 no requests", int'(gnt_vld), 0);
    pulse_done();
    chk(!gnt_vld, "R9 done while idle", int'(gnt_vld), 0);
    req = 7'b0000100;
    @(negedge clk);
    expect_grant("R4 idle grant", 2);
    req = 7'b1110110;
    pulse_done();
    expect_grant("R6 write 0 hog", 2);
    req = 7'b1110010;
    pulse_done();
    expect_grant("R5 read above writes", 1);

    mdl_on = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      req  = ($urandom % 5 == 0) ? 7'd0 : 7'($urandom);
      done = ($urandom % 3 == 0);
      @(negedge clk);
    end
    done = 1'b0;
    mdl_on = 1'b0;
    fin = 1'b1;
  end

  initial begin
    fork
      begin
        wait (fin);
      end
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule